// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small single-cycle processor for a 32-bit load/store instruction set. On every clock it fetches one instruction word from a dedicated instruction port, decodes it, reads two source registers and computes a result in the ALU. It can then perform a word access to data memory, write the result back to the register file, and choose the next program counter. Thirteen instructions are supported: register add, subtract and set-on-less-than; immediate add, set-on-less-than, AND and OR; load-upper-immediate; word load and store; branch on equal and branch on not equal; and an absolute jump.

Instruction memory is read combinationally through `imem_addr` and `imem_data`. Data memory is a word-wide array. It returns `dmem_rdata` combinationally for the address on `dmem_addr` and commits a store on the rising clock edge while `dmem_we` is high. All addresses are byte addresses, and word accesses use addresses that are multiples of four. Exceptions, multiply/divide, shifts, pipelining, caches and sub-word accesses are not provided.

Top module: `sc32_core`

## Requirements
- R1: While `rst_n` is low the program counter is held at 0, so `imem_addr` is 0 and `dmem_we` is 0. The first fetch after reset is from address 0.
- R2: Any instruction other than a branch or jump (opcodes 4, 5 and 2) advances the program counter by exactly 4.
- R3: Opcode 0 selects register operations by the function field in bits [5:0]: 32 is add, 34 is subtract, and 42 is signed set-less-than. Each writes field rd (bits [15:11]) from rs (bits [25:21]) and rt (bits [20:16]). Set-less-than writes 1 or 0.
- R4: Immediate operations write rt. Opcode 8 (add) and opcode 10 (signed set-less-than) sign-extend the 16-bit immediate in bits [15:0]. Opcode 12 (AND) and opcode 13 (OR) zero-extend it.
- R5: Opcode 15 writes the immediate into bits [31:16] of rt and clears bits [15:0]. A following OR-immediate fills in the low half, which completes any 32-bit constant.
- R6: Opcode 35 loads the data word at rs + sign-extended offset into rt. Opcode 43 drives that address on `dmem_addr`, drives rt on `dmem_wdata` and raises `dmem_we` for that one instruction only.
- R7: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. A taken branch goes to PC+4 plus the sign-extended offset times 4; otherwise the core goes to PC+4.
- R8: Opcode 2 always jumps to {PC+4[31:28], bits [25:0], 2'b00}.
- R9: Register 0 always reads as zero, and a write aimed at it leaves it zero.
- R10: A load whose destination is also its base register forms its address from the old base value and writes the loaded word at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for data load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the rising edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr` |

## Verification
Register read and register write-back meet in a single instruction when a load names the same register as base and destination. The core must build the address from the old value while the loaded word lands at the closing edge. A write to register 0 combined with a later read of it falls in the same category. The bench program contains both cases, together with a store that reads a register written one cycle earlier. A behavioural interpreter steps alongside the core and checks the fetch address and every store's strobe, address and data on each clock. At the end the program stores its registers to memory, and those words are compared with the interpreter's memory image.

// File: rtl/sc32_core.sv
module sc32_core #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam int NREG = 32;

  typedef enum logic [2:0] {A_ADD, A_SUB, A_SLT, A_AND, A_OR, A_LUI} alu_e;

  logic [31:0] pc;
  logic [31:0] rf [NREG];

  wire [5:0]  op    = imem_data[31:26];
  wire [4:0]  rs    = imem_data[25:21];
  wire [4:0]  rt    = imem_data[20:16];
  wire [4:0]  rd    = imem_data[15:11];
  wire [5:0]  fn    = imem_data[5:0];
  wire [15:0] imm   = imem_data[15:0];
  wire [25:0] jaddr = imem_data[25:0];

  logic reg_we, use_rd, use_imm, zext, is_ld, is_st, is_beq, is_bne, is_j;
  alu_e alu_op;

  always_comb begin
    reg_we = 1'b0; use_rd = 1'b0; use_imm = 1'b1; zext = 1'b0;
    is_ld = 1'b0; is_st = 1'b0; is_beq = 1'b0; is_bne = 1'b0; is_j = 1'b0;
    alu_op = A_ADD;
    case (op)
      6'd0: begin
        use_rd = 1'b1; use_imm = 1'b0;
        case (fn)
          6'd32: begin reg_we = 1'b1; alu_op = A_ADD; end
          6'd34: begin reg_we = 1'b1; alu_op = A_SUB; end
          6'd42: begin reg_we = 1'b1; alu_op = A_SLT; end
          default: ;
        endcase
      end
      6'd35: begin reg_we = 1'b1; is_ld = 1'b1; end
      6'd43: is_st = 1'b1;
      6'd4:  begin is_beq = 1'b1; use_imm = 1'b0; alu_op = A_SUB; end
      6'd5:  begin is_bne = 1'b1; use_imm = 1'b0; alu_op = A_SUB; end
      6'd2:  is_j = 1'b1;
      6'd8:  reg_we = 1'b1;
      6'd10: begin reg_we = 1'b1; alu_op = A_SLT; end
      6'd12: begin reg_we = 1'b1; zext = 1'b1; alu_op = A_AND; end
      6'd13: begin reg_we = 1'b1; zext = 1'b1; alu_op = A_OR; end
      6'd15: begin reg_we = 1'b1; alu_op = A_LUI; end
      default: ;
    endcase
  end

  wire [31:0] rs_val  = (rs == 5'd0) ? 32'h0 : rf[rs];
  wire [31:0] rt_val  = (rt == 5'd0) ? 32'h0 : rf[rt];
  wire [31:0] imm_ext = zext ? {16'h0, imm} : {{16{imm[15]}}, imm};
  wire [31:0] opb     = use_imm ? imm_ext : rt_val;

  logic [31:0] alu_y;
  always_comb begin
    case (alu_op)
      A_SUB:   alu_y = rs_val - opb;
      A_SLT:   alu_y = {31'h0, $signed(rs_val) < $signed(opb)};
      A_AND:   alu_y = rs_val & opb;
      A_OR:    alu_y = rs_val | opb;
      A_LUI:   alu_y = {imm, 16'h0};
      default: alu_y = rs_val + opb;
    endcase
  end

  wire        zero_y = (alu_y == 32'h0);
  wire        take   = (is_beq & zero_y) | (is_bne & ~zero_y);
  wire [31:0] pc4    = pc + 32'd4;
  wire [31:0] pc_nxt = is_j ? {pc4[31:28], jaddr, 2'b00}
                     : take ? pc4 + {imm_ext[29:0], 2'b00}
                     : pc4;
  wire [4:0]  wa     = use_rd ? rd : rt;
  wire [31:0] wd     = is_ld ? dmem_rdata : alu_y;

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = rst_n & is_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= RESET_PC;
    else        pc <= pc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 32'h0;
    end else if (reg_we && wa != 5'd0) begin
      rf[wa] <= wd;
    end
  end
endmodule

// File: rtl/sc32_core_chk.sv
module sc32_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_data
);
  wire [5:0]  op     = imem_data[31:26];
  wire [31:0] pc_p4  = imem_addr + 32'd4;
  wire [31:0] br_tgt = pc_p4 + {{14{imem_data[15]}}, imem_data[15:0], 2'b00};
  wire        is_br  = (op == 6'd4) || (op == 6'd5);
  wire        is_jmp = (op == 6'd2);

  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> imem_addr == 32'h0);

  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_br && !is_jmp) |=> imem_addr == $past(pc_p4));

  assert_branch_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_br |=> (imem_addr == $past(pc_p4)) || (imem_addr == $past(br_tgt)));

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_jmp |=> imem_addr == {$past(pc_p4[31:28]), $past(imem_data[25:0]), 2'b00});
endmodule

bind sc32_core sc32_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data)
);

// File: tb/sc32_core_tb.sv
module sc32_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we;

  always #4 clk = ~clk;

  sc32_core u_dut (.*);

  logic [31:0] rom  [64];
  logic [31:0] dmem [64];
  logic [31:0] mmem [64];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  int checks = 0, fails = 0;
  bit finished = 0;

  assign imem_data  = rom[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int fn, int s, int t, int d);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int o, int s, int t, int im);
    return {6'(o), 5'(s), 5'(t), 16'(im)};
  endfunction
  function automatic logic [31:0] enc_j(int o, int a);
    return {6'(o), 26'(a)};
  endfunction

  function automatic string tag_of(logic [5:0] o);
    case (o)
      6'd0: return "R3";
      6'd8, 6'd10, 6'd12, 6'd13: return "R4";
      6'd15: return "R5";
      6'd35, 6'd43: return "R6";
      6'd4, 6'd5: return "R7";
      6'd2: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] ins, a, b, se, ze;
    logic [5:0] o;
    ins = rom[mpc[7:2]];
    o = ins[31:26];
    a = mreg[ins[25:21]];
    b = mreg[ins[20:16]];
    se = {{16{ins[15]}}, ins[15:0]};
    ze = {16'h0, ins[15:0]};
    mpc = mpc + 4;
    case (o)
      6'd0: case (ins[5:0])
        6'd32: mreg[ins[15:11]] = a + b;
        6'd34: mreg[ins[15:11]] = a - b;
        6'd42: mreg[ins[15:11]] = ($signed(a) < $signed(b)) ? 1 : 0;
        default: ;
      endcase
      6'd35: mreg[ins[20:16]] = mmem[(a + se) >> 2];
      6'd43: mmem[(a + se) >> 2] = b;
      6'd4:  if (a == b) mpc = mpc + (se << 2);
      6'd5:  if (a != b) mpc = mpc + (se << 2);
      6'd2:  mpc = {mpc[31:28], ins[25:0], 2'b00};
      6'd8:  mreg[ins[20:16]] = a + se;
      6'd10: mreg[ins[20:16]] = ($signed(a) < $signed(se)) ? 1 : 0;
      6'd12: mreg[ins[20:16]] = a & ze;
      6'd13: mreg[ins[20:16]] = a | ze;
      6'd15: mreg[ins[20:16]] = {ins[15:0], 16'h0};
      default: ;
    endcase
    mreg[0] = 32'h0;
  endtask

  always @(posedge clk) if (rst_n && !finished) model_step();

  task automatic cycle_compare();
    logic [31:0] ins;
    string tg;
    ins = rom[mpc[7:2]];
    tg = tag_of(ins[31:26]);
    check(tg, "fetch address", imem_addr, mpc);
    check(tg, "store strobe", {31'h0, dmem_we}, {31'h0, ins[31:26] == 6'd43});
    if (ins[31:26] == 6'd43) begin
      check("R6", "store address", dmem_addr, mreg[ins[25:21]] + {{16{ins[15]}}, ins[15:0]});
      check("R6", "store data", dmem_wdata, mreg[ins[20:16]]);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin rom[i] = 32'h0; dmem[i] = 32'h0; mmem[i] = 32'h0; end
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    mpc = 32'h0;
    rom[0]  = enc_i(8, 0, 1, 64);
    rom[1]  = enc_i(8, 0, 2, 4);
    rom[2]  = enc_r(32, 0, 0, 3);
    rom[3]  = enc_r(32, 1, 0, 4);
    rom[4]  = enc_i(35, 4, 5, 0);
    rom[5]  = enc_r(32, 3, 5, 3);
    rom[6]  = enc_i(8, 4, 4, 4);
    rom[7]  = enc_i(8, 2, 2, -1);
    rom[8]  = enc_i(5, 2, 0, -5);
    rom[9]  = enc_i(43, 1, 3, 16);
    rom[10] = enc_i(35, 1, 6, 0);
    rom[11] = enc_i(35, 1, 7, 4);
    rom[12] = enc_i(43, 1, 7, 0);
    rom[13] = enc_i(43, 1, 6, 4);
    rom[14] = enc_r(42, 7, 6, 8);
    rom[15] = enc_i(10, 6, 9, -1);
    rom[16] = enc_r(34, 7, 6, 10);
    rom[17] = enc_i(15, 0, 11, 16'hABCD);
    rom[18] = enc_i(13, 11, 11, 16'h8765);
    rom[19] = enc_i(12, 11, 12, 16'hF0F0);
    rom[20] = enc_i(8, 0, 0, 5);
    rom[21] = enc_r(32, 0, 0, 13);
    rom[22] = enc_i(4, 8, 9, 1);
    rom[23] = enc_i(4, 13, 0, 1);
    rom[24] = enc_i(8, 0, 14, 99);
    rom[25] = enc_i(8, 1, 20, 8);
    rom[26] = enc_i(35, 20, 20, 0);
    rom[27] = enc_r(42, 6, 7, 15);
    rom[28] = enc_i(10, 7, 16, 0);
    rom[29] = enc_j(2, 31);
    rom[30] = enc_i(8, 0, 14, 77);
    for (int k = 0; k < 21; k++) rom[31 + k] = enc_i(43, 0, k, 128 + 4 * k);
    rom[52] = enc_j(2, 52);
    dmem[16] = 32'd5;  dmem[17] = -32'sd3; dmem[18] = 32'd100; dmem[19] = 32'd7;
    mmem[16] = 32'd5;  mmem[17] = -32'sd3; mmem[18] = 32'd100; mmem[19] = 32'd7;

    repeat (3) @(negedge clk);
    check("R1", "fetch address in reset", imem_addr, 32'h0);
    check("R1", "store strobe in reset", {31'h0, dmem_we}, 32'h0);
    rst_n = 1'b1;
    for (int c = 0; c < 90; c++) begin
      cycle_compare();
      @(negedge clk);
    end
    finished = 1;
    for (int w = 0; w < 64; w++) begin
      string tg;
      tg = (w == 32) ? "R9" : (w == 45) ? "R9" : (w == 52) ? "R10" : "R6";
      check(tg, $sformatf("memory word %0d", w), dmem[w], mmem[w]);
    end
    check("R10", "self-based load result", dmem[52], 32'd100);
    check("R9", "register 0 image", dmem[32], 32'h0);
    check("R5", "lui/ori constant", dmem[43], 32'hABCD8765);
    check("R4", "andi zero-extend", dmem[44], 32'h00008060);
    check("R3", "slt signed true", dmem[40], 32'd1);
    check("R4", "slti signed false", dmem[41], 32'd0);
    check("R3", "sub result", dmem[42], 32'hFFFFFFF8);
    check("R7", "skipped by taken beq", dmem[46], 32'h0);
    check("R8", "skipped by jump", dmem[46], 32'h0);
    check("R6", "array sum", dmem[20], 32'd109);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule